// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received frames from a byte stream into memory buffers that software describes with a linked list of four-word descriptors. Software builds the list, marks each descriptor as hardware-owned, and starts the engine by writing the address of the first descriptor. The engine then fetches each descriptor and checks its ownership flag. It stores the next frame into that descriptor's buffer and writes a status word back. It then follows the link to the next descriptor, and stops when the link is zero.

All pointers are word addresses on a single memory port. The memory accepts one request per cycle and returns read data one cycle after it samples a read. A descriptor at word address P holds the next-descriptor pointer at P, the buffer pointer at P+1, a size word at P+2 (bits 31:16 are the buffer offset in words, bits 15:0 the buffer length in bytes) and the status word at P+3. Frame bytes are packed little-endian: byte k of a frame goes to bits 8*(k mod 4) of buffer word k/4, and unused upper byte lanes of the last word are written as zero.

Registers are selected by `reg_addr` and read with one cycle of latency. Address 0 is the head pointer, 1 the completion pointer, 2 the control register (bit 0 = ignore ownership) and 3 the dropped-frame count.

Top module: `rxdesc_dma`

## Requirements
- R1: A write to register 0 while the engine is idle loads a nonzero descriptor address and starts a fetch of that descriptor's four words. A write to register 0 while the engine is busy, or in host error, has no effect.
- R2: With control bit 0 clear, a fetched descriptor whose status bit 29 (ownership) is 0 raises `host_err_irq`. The signal stays set until reset, the engine makes no further memory access, and later frames are not stored.
- R3: With control bit 0 set, a descriptor is used whatever its bit 29 holds, and its write-back still carries bit 29 as 0.
- R4: Frame bytes are stored little-endian starting at word address buffer pointer + offset, with zeros in the unused lanes of the final word. No word past the last stored byte is written.
- R5: After the last byte of a frame, status word P+3 is written as: bit 31 = 1, bit 30 = 1, bit 29 = 0, bit 28 = end of chain, bit 27 = overrun, bits 15:0 = stored byte count, and all other bits 0.
- R6: After a write-back the engine moves to the descriptor named by the next pointer. When that pointer is zero it sets bit 28 in the write-back and halts until register 0 is written again.
- R7: A frame longer than the buffer length keeps only the first buffer-length bytes, reports that count, and sets bit 27.
- R8: `rx_done_irq` rises with each write-back. It stays set until register 1 is written with the address of the most recently completed descriptor; a write of any other value leaves it set.
- R9: When a completion and a register 1 write land in the same cycle, `rx_done_irq` remains set, even if the written value matches the previously completed descriptor.
- R10: A frame whose start byte arrives while the engine is idle, fetching, writing back or in host error is dropped, and register 3 counts it up by one.
- R11: Register 0 reads the current descriptor address while the engine is active or in host error, and reads 0 when it is idle.
- R12: After reset both interrupts are 0, no memory request is made, and all four registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| rx_valid | input | 1 | Stream byte valid |
| rx_sop | input | 1 | First byte of a frame |
| rx_eop | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Stream byte |
| rx_done_irq | output | 1 | Completed frames not yet acknowledged |
| host_err_irq | output | 1 | Ownership fault, held until reset |

## Verification
A descriptor's completion and a software acknowledgement write to the completion pointer can fall in the same clock edge. The bench provokes this by placing the register 1 write in the cycle right after the final byte of a frame, which is the write-back cycle. The value it writes is the address of the descriptor completed before. The interrupt is judged correct only if it is still set afterwards, and it must then clear when the new descriptor's address is written. Random frame contents and lengths, together with the full-buffer, one-byte and truncated cases, are compared word by word against a model built from the frame bytes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_CHECK, ST_READY, ST_RECV, ST_WBACK, ST_HERR
  } walk_st_t;

  localparam int FLG_SOP = 31;
  localparam int FLG_EOP = 30;
  localparam int FLG_OWN = 29;
  localparam int FLG_EOQ = 28;
  localparam int FLG_OVR = 27;

  localparam logic [1:0] REG_HEAD = 2'd0;
  localparam logic [1:0] REG_CPTR = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_DROP = 2'd3;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             rx_valid,
  input  logic             rx_eop,
  input  logic [7:0]       rx_data,
  input  logic [LEN_W-1:0] buf_len,
  output logic             wr_vld,
  output logic [LEN_W-3:0] wr_idx,
  output logic [31:0]      wr_data,
  output logic             frame_end,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_ovr
);
  logic [LEN_W-1:0] cnt;
  logic [31:0]      acc;
  logic             ovr;
  logic             take, keep;
  logic [1:0]       lane;
  logic [31:0]      merged;

  always_comb begin
    take   = act && rx_valid;
    keep   = take && (cnt < buf_len);
    lane   = cnt[1:0];
    merged = acc;
    if (keep) merged[8*int'(lane) +: 8] = rx_data;
    // flush a full word, or the partial word at frame end
    wr_vld    = (keep && (lane == 2'd3 || rx_eop)) ||
                (take && rx_eop && !keep && cnt[1:0] != 2'd0);
    wr_idx    = cnt[LEN_W-1:2];
    wr_data   = merged;
    frame_end = take && rx_eop;
    frame_len = keep ? cnt + 1'b1 : cnt;
    frame_ovr = ovr || (take && !keep);
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      cnt <= '0;
      acc <= '0;
      ovr <= 1'b0;
    end else if (take) begin
      ovr <= frame_ovr;
      if (keep) begin
        cnt <= cnt + 1'b1;
        acc <= (lane == 2'd3) ? 32'd0 : merged;
      end
    end
  end
endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
  import rxd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [AW-1:0]    arm_ptr,
  input  logic             own_ignore,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic             pk_wr_vld,
  input  logic [LEN_W-3:0] pk_wr_idx,
  input  logic [31:0]      pk_wr_data,
  input  logic             pk_end,
  input  logic [LEN_W-1:0] pk_len,
  input  logic             pk_ovr,
  output logic             pk_act,
  output logic [LEN_W-1:0] buf_len,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    cur_ptr_rd,
  output logic             done_fire,
  output logic [AW-1:0]    done_ptr,
  output logic             drop_pulse,
  output logic             host_err
);
  walk_st_t         st;
  logic [AW-1:0]    cur;
  logic [31:0]      w_next, w_buf, w_size;
  logic             w_own;
  logic [1:0]       fcnt;
  logic             q1_v, q2_v;
  logic [1:0]       q1_i, q2_i;
  logic [LEN_W-1:0] wb_len;
  logic             wb_ovr;
  logic             next_null;
  logic [31:0]      wb_word;
  logic [AW-1:0]    data_addr;

  always_comb begin
    pk_act     = (st == ST_READY && rx_valid && rx_sop) || st == ST_RECV;
    buf_len    = w_size[LEN_W-1:0];
    next_null  = (w_next == 32'd0);
    cur_ptr_rd = (st == ST_IDLE) ? '0 : cur;
    done_fire  = (st == ST_WBACK);
    done_ptr   = cur;
    drop_pulse = rx_valid && rx_sop && st != ST_READY && st != ST_RECV;
    data_addr  = w_buf[AW-1:0] + AW'(w_size[31:16]) + AW'(pk_wr_idx);
    wb_word    = '0;
    wb_word[FLG_SOP]     = 1'b1;
    wb_word[FLG_EOP]     = 1'b1;
    wb_word[FLG_OWN]     = 1'b0;
    wb_word[FLG_EOQ]     = next_null;
    wb_word[FLG_OVR]     = wb_ovr;
    wb_word[LEN_W-1:0]   = wb_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur       <= '0;
      w_next    <= '0;
      w_buf     <= '0;
      w_size    <= '0;
      w_own     <= 1'b0;
      fcnt      <= '0;
      q1_v      <= 1'b0;
      q1_i      <= '0;
      q2_v      <= 1'b0;
      q2_i      <= '0;
      wb_len    <= '0;
      wb_ovr    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      host_err  <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      q1_v    <= 1'b0;
      q2_v    <= q1_v;
      q2_i    <= q1_i;
      if (q2_v) begin
        case (q2_i)
          2'd0:    w_next <= mem_rdata;
          2'd1:    w_buf  <= mem_rdata;
          2'd2:    w_size <= mem_rdata;
          default: w_own  <= mem_rdata[FLG_OWN];
        endcase
      end
      case (st)
        ST_IDLE: begin
          if (arm && arm_ptr != '0) begin
            cur  <= arm_ptr;
            fcnt <= '0;
            st   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          mem_req  <= 1'b1;
          mem_addr <= cur + AW'(fcnt);
          q1_v     <= 1'b1;
          q1_i     <= fcnt;
          fcnt     <= fcnt + 1'b1;
          if (fcnt == 2'd3) st <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (q2_v && q2_i == 2'd3) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!w_own && !own_ignore) begin
            st       <= ST_HERR;
            host_err <= 1'b1;
          end else begin
            st <= ST_READY;
          end
        end
        ST_READY, ST_RECV: begin
          if (pk_end) begin
            wb_len <= pk_len;
            wb_ovr <= pk_ovr;
            st     <= ST_WBACK;
          end else if (pk_act) begin
            st <= ST_RECV;
          end
          if (pk_wr_vld) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= data_addr;
            mem_wdata <= pk_wr_data;
          end
        end
        ST_WBACK: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur + AW'(3);
          mem_wdata <= wb_word;
          if (next_null) begin
            st <= ST_IDLE;
          end else begin
            cur  <= w_next[AW-1:0];
            fcnt <= '0;
            st   <= ST_FETCH;
          end
        end
        default: st <= ST_HERR;
      endcase
    end
  end
endmodule

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DROP_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          arm,
  output logic [AW-1:0] arm_ptr,
  output logic          own_ignore,
  input  logic [AW-1:0] cur_ptr,
  input  logic          done_fire,
  input  logic [AW-1:0] done_ptr,
  input  logic          drop_pulse,
  output logic          rx_done_irq
);
  logic [31:0]       cptr;
  logic [AW-1:0]     last_done;
  logic [DROP_W-1:0] drop_cnt;
  logic              cp_wr;

  always_comb begin
    arm     = reg_we && reg_addr == REG_HEAD;
    arm_ptr = reg_wdata[AW-1:0];
    cp_wr   = reg_we && reg_addr == REG_CPTR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cptr        <= '0;
      own_ignore  <= 1'b0;
      last_done   <= '0;
      drop_cnt    <= '0;
      rx_done_irq <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      if (cp_wr) cptr <= reg_wdata;
      if (reg_we && reg_addr == REG_CTRL) own_ignore <= reg_wdata[0];
      if (drop_pulse) drop_cnt <= drop_cnt + 1'b1;
      // a completion in the same cycle wins over an acknowledge
      if (done_fire) begin
        last_done   <= done_ptr;
        rx_done_irq <= 1'b1;
      end else if (cp_wr && reg_wdata == 32'(last_done)) begin
        rx_done_irq <= 1'b0;
      end
      case (reg_addr)
        REG_HEAD: reg_rdata <= 32'(cur_ptr);
        REG_CPTR: reg_rdata <= cptr;
        REG_CTRL: reg_rdata <= {31'd0, own_ignore};
        default:  reg_rdata <= 32'(drop_cnt);
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma #(
  parameter int AW     = 16,
  parameter int LEN_W  = 16,
  parameter int DROP_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic          rx_eop,
  input  logic [7:0]    rx_data,
  output logic          rx_done_irq,
  output logic          host_err_irq
);
  logic             arm, own_ignore, done_fire, drop_pulse;
  logic [AW-1:0]    arm_ptr, cur_ptr, done_ptr;
  logic             pk_act, pk_wr_vld, pk_end, pk_ovr;
  logic [LEN_W-3:0] pk_wr_idx;
  logic [31:0]      pk_wr_data;
  logic [LEN_W-1:0] pk_len, buf_len;

  rxd_regs #(.AW(AW), .DROP_W(DROP_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arm(arm),
    .arm_ptr(arm_ptr), .own_ignore(own_ignore), .cur_ptr(cur_ptr),
    .done_fire(done_fire), .done_ptr(done_ptr), .drop_pulse(drop_pulse),
    .rx_done_irq(rx_done_irq)
  );

  rxd_packer #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst(rst), .act(pk_act), .rx_valid(rx_valid),
    .rx_eop(rx_eop), .rx_data(rx_data), .buf_len(buf_len),
    .wr_vld(pk_wr_vld), .wr_idx(pk_wr_idx), .wr_data(pk_wr_data),
    .frame_end(pk_end), .frame_len(pk_len), .frame_ovr(pk_ovr)
  );

  rxd_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .arm(arm), .arm_ptr(arm_ptr),
    .own_ignore(own_ignore), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .pk_wr_vld(pk_wr_vld), .pk_wr_idx(pk_wr_idx), .pk_wr_data(pk_wr_data),
    .pk_end(pk_end), .pk_len(pk_len), .pk_ovr(pk_ovr), .pk_act(pk_act),
    .buf_len(buf_len), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_ptr_rd(cur_ptr), .done_fire(done_fire), .done_ptr(done_ptr),
    .drop_pulse(drop_pulse), .host_err(host_err_irq)
  );
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        rx_done_irq,
  input logic        host_err_irq
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    host_err_irq |=> host_err_irq); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (host_err_irq && $past(host_err_irq)) |-> !mem_req); // R2
  AST_DONE_WITH_WB: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done_irq) |-> (mem_req && mem_we && mem_wdata[30] && !mem_wdata[29])); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_done_irq && !(reg_we && reg_addr == 2'd1)) |=> rx_done_irq); // R8
endmodule

bind rxdesc_dma rxdesc_dma_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .rx_done_irq(rx_done_irq), .host_err_irq(host_err_irq)
);

// File: tb/rxdesc_dma_tb.sv
module rxdesc_dma_tb;
  localparam int AW = 16;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = 32'd0;
  logic [31:0]   reg_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = 32'd0;
  logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [7:0]    rx_data = 8'd0;
  logic          rx_done_irq, host_err_irq;

  logic [31:0] mem [0:1023];
  logic [7:0]  fb [0:63];
  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  rxdesc_dma u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_data(rx_data), .rx_done_irq(rx_done_irq),
    .host_err_irq(host_err_irq)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic put_desc(input int p, input int nxt, input int bp, input int off,
                          input int blen, input logic [31:0] st);
    mem[p]   = 32'(nxt);
    mem[p+1] = 32'(bp);
    mem[p+2] = {16'(off), 16'(blen)};
    mem[p+3] = st;
    for (int k = 0; k < 16; k++) mem[bp+off+k] = SENT;
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  task automatic send(input int len, input bit cp_wr, input logic [31:0] cp_val);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == len - 1); rx_data = fb[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    if (cp_wr) begin
      reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = cp_val;
      @(negedge clk);
      reg_we = 1'b0;
    end
  endtask

  function automatic logic [31:0] status_exp(input int len, input int blen, input bit eoq);
    int stored = (len < blen) ? len : blen;
    return {1'b1, 1'b1, 1'b0, eoq, (len > blen), 11'd0, 16'(stored)};
  endfunction

  function automatic logic [31:0] word_exp(input int k, input int stored);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (k*4 + b < stored) w[8*b +: 8] = fb[k*4 + b];
    return w;
  endfunction

  task automatic check_frame(input int p, input int base, input int len,
                             input int blen, input bit eoq);
    int stored = (len < blen) ? len : blen;
    int nw = (stored + 3) / 4;
    check("R5 R7 status word", mem[p+3], status_exp(len, blen, eoq));
    for (int k = 0; k < nw; k++) check("R4 buffer word", mem[base+k], word_exp(k, stored));
    check("R4 R7 word past data untouched", mem[base+nw], SENT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    int len0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    idle(5);
    // R12: reset state
    check("R12 rx_done_irq", 32'(rx_done_irq), 0);
    check("R12 host_err_irq", 32'(host_err_irq), 0);
    check("R12 mem_req", 32'(mem_req), 0);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), r);
      check("R12 register reads zero", r, 0);
    end

    // R1 R4 R5 R6: three-descriptor chain
    put_desc(32'h40, 32'h50, 32'h100, 0, 48, 32'h2000_0000);
    put_desc(32'h50, 32'h60, 32'h180, 2, 48, 32'h2000_0000);
    put_desc(32'h60, 0,      32'h200, 0, 48, 32'h2000_0000);
    reg_wr(2'd0, 32'h40);
    reg_rd(2'd0, r);
    check("R11 head reads current descriptor", r, 32'h40);
    idle(15);
    len0 = 1 + int'($urandom % 47);
    fill(len0);
    send(len0, 1'b0, 0);
    idle(3);
    check("R8 done irq after completion", 32'(rx_done_irq), 1);
    check_frame(32'h40, 32'h100, len0, 48, 1'b0);
    idle(12);
    fill(48);
    send(48, 1'b0, 0);
    idle(15);
    check_frame(32'h50, 32'h182, 48, 48, 1'b0);
    fill(1);
    send(1, 1'b0, 0);
    idle(15);
    check_frame(32'h60, 32'h200, 1, 48, 1'b1);
    reg_rd(2'd0, r);
    check("R6 head reads zero after halt", r, 0);

    // R8: acknowledge
    reg_wr(2'd1, 32'h40);
    idle(2);
    check("R8 stale ack keeps irq", 32'(rx_done_irq), 1);
    reg_wr(2'd1, 32'h60);
    idle(2);
    check("R8 matching ack clears irq", 32'(rx_done_irq), 0);

    // R10: frame while idle is dropped
    fill(8);
    send(8, 1'b0, 0);
    idle(4);
    reg_rd(2'd3, r);
    check("R10 drop count while idle", r, 1);
    check("R10 no completion while idle", 32'(rx_done_irq), 0);

    // R7: truncation
    put_desc(32'h70, 0, 32'h280, 0, 10, 32'h2000_0000);
    reg_wr(2'd0, 32'h70);
    idle(15);
    fill(17);
    send(17, 1'b0, 0);
    idle(15);
    check_frame(32'h70, 32'h280, 17, 10, 1'b1);
    reg_wr(2'd1, 32'h70);

    // R9 R1: completion and acknowledge in the same cycle; busy head write ignored
    put_desc(32'h80, 32'h90, 32'h300, 0, 32, 32'h2000_0000);
    put_desc(32'h90, 0,      32'h340, 0, 32, 32'h2000_0000);
    reg_wr(2'd0, 32'h80);
    idle(15);
    reg_wr(2'd0, 32'hA0);
    idle(3);
    fill(20);
    send(20, 1'b0, 0);
    idle(3);
    check_frame(32'h80, 32'h300, 20, 32, 1'b0);
    idle(12);
    fill(9);
    send(9, 1'b1, 32'h80);
    idle(2);
    check("R9 same-cycle ack keeps irq", 32'(rx_done_irq), 1);
    check_frame(32'h90, 32'h340, 9, 32, 1'b1);
    check("R1 busy head write ignored", mem[32'hA3], 32'd0);
    reg_wr(2'd1, 32'h90);
    idle(2);
    check("R8 ack of latest clears irq", 32'(rx_done_irq), 0);

    // R3: ignore ownership
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, r);
    check("R3 control readback", r, 1);
    put_desc(32'hB0, 0, 32'h380, 0, 16, 32'h0);
    reg_wr(2'd0, 32'hB0);
    idle(15);
    fill(13);
    send(13, 1'b0, 0);
    idle(15);
    check("R3 no host error", 32'(host_err_irq), 0);
    check_frame(32'hB0, 32'h380, 13, 16, 1'b1);
    reg_wr(2'd1, 32'hB0);

    // R2: ownership fault
    reg_wr(2'd2, 32'h0);
    put_desc(32'hC0, 0, 32'h3C0, 0, 16, 32'h0);
    reg_wr(2'd0, 32'hC0);
    idle(15);
    check("R2 host error raised", 32'(host_err_irq), 1);
    fill(6);
    send(6, 1'b0, 0);
    idle(10);
    check("R2 buffer untouched in error", mem[32'h3C0], SENT);
    check("R2 status untouched in error", mem[32'hC3], 32'h0);
    reg_rd(2'd3, r);
    check("R10 drop count in error", r, 2);
    reg_wr(2'd0, 32'h40);
    idle(10);
    check("R2 error sticky", 32'(host_err_irq), 1);
    reg_rd(2'd0, r);
    check("R11 head in error holds faulting descriptor", r, 32'hC0);
    report();
  end
endmodule